// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block keeps the request and in-service state for 256 interrupt vectors. Each state is a bit array of eight 32-bit words. A vector selects its word with bits 7:5 and its bit within the word with bits 4:0.

From each array the block continuously derives the highest set vector. The scan starts at word 7 and works down, and in the first word that holds any set bit it takes the most significant one. The result is that word's index times 32 plus the bit position, or 0 when the array is empty.

Four special classes bypass the request array: SMI, NMI, INIT and external interrupt. Each has its own pending flag and a stored vector. An urgent summary covers SMI, NMI and INIT but leaves out the external interrupt. A pending output tells the CPU-side logic that something should be taken. Acceptance and end-of-interrupt strobes then move vectors between the two arrays or retire special flags. Delivering the interrupt to a CPU is left to the surrounding logic.

Top module: `irq_vector_tracker`

## Requirements
- R1: After reset, `irr_top`, `isr_top` and `spec_vec` are 0, and `int_pending` and `urgent_pending` are 0. All flags, stored vectors and array bits are cleared.
- R2: A request with `req_kind` = 0 (fixed) sets the array bit of `req_vec`. From the next cycle, `irr_top` shows the highest set request vector, found by a scan from word 7 down to word 0.
- R3: When an array has no bit set, its highest-vector output (`irr_top` or `isr_top`) is 0.
- R4: `accept` with no special flag pending and a non-empty request array clears the `irr_top` bit in the request array and sets the same bit in the in-service array, in the same edge.
- R5: `eoi` clears the highest set in-service bit. `eoi` with an empty in-service array has no effect.
- R6: A fixed request for a vector whose request bit is already set has no further effect. One accept then empties that vector from the request array.
- R7: `req_kind` 1 = SMI, 2 = NMI, 3 = INIT and 4 = external. Each of these sets its own flag and stores `req_vec`, and the request array is left untouched. `spec_vec` shows the stored vector of the highest-ranked pending flag, ranked SMI > NMI > INIT > external, or 0 when no flag is set.
- R8: `urgent_pending` is 1 exactly when the SMI, NMI or INIT flag is set. The external flag alone leaves it at 0.
- R9: `int_pending` is 1 when the request array is non-empty and `irr_top[7:4]` is greater than `isr_top[7:4]`. It is also 1 whenever any special flag is set, and it is 0 otherwise.
- R10: `accept` while any special flag is set clears only the highest-ranked pending flag. Both arrays stay unchanged.
- R11: `accept` with no special flag set and an empty request array leaves both arrays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_kind | input | 3 | Request class: 0 fixed, 1 SMI, 2 NMI, 3 INIT, 4 external |
| req_vec | input | 8 | Vector of the request |
| accept | input | 1 | Take the highest special flag, else the highest request vector |
| eoi | input | 1 | End of interrupt: retire the highest in-service vector |
| irr_top | output | 8 | Highest set request vector, 0 if none |
| isr_top | output | 8 | Highest set in-service vector, 0 if none |
| spec_vec | output | 8 | Stored vector of the highest-ranked special flag, 0 if none |
| urgent_pending | output | 1 | SMI, NMI or INIT flag set |
| int_pending | output | 1 | Something should be taken (R9) |

## Verification
The bench places vectors in different words and in different orders. A scan that ran from the wrong end, or that stopped at the wrong word, would then report a lower vector instead of the highest one. It accepts and retires vectors in chains, so the in-service top falls back to an older vector. A swap that was not atomic would leave a vector in both arrays or lose it. A design that handled EOI wrongly would clear the wrong bit.

The bench also repeats a request, strobes accept on an empty array, and holds requests of equal and of higher class against the in-service class. A duplicate request that was counted twice, a phantom acceptance of vector 0, or a class comparison that used `>=` would each show up at `irr_top`, `isr_top` or `int_pending`. The special flags are retired one by one while a fixed vector waits. A wrong rank order, an external flag counted as urgent, or an acceptance that also touched the arrays would each surface at `spec_vec`, `urgent_pending` or the array tops.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SPECIAL = 4;

    typedef enum logic [2:0] {
        KIND_FIXED = 3'd0,
        KIND_SMI   = 3'd1,
        KIND_NMI   = 3'd2,
        KIND_INIT  = 3'd3,
        KIND_EXT   = 3'd4
    } req_kind_e;
endpackage

// File: rtl/vec_bitmap.sv
module vec_bitmap #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int VEC_W = $clog2(WORDS * WORD_W),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_en,
    input  logic [VEC_W-1:0]              set_vec,
    input  logic                          clr_en,
    input  logic [VEC_W-1:0]              clr_vec,
    output logic [WORDS-1:0][WORD_W-1:0]  words
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] set_mask;
        logic [WORD_W-1:0] clr_mask;

        always_comb begin
            set_mask = '0;
            clr_mask = '0;
            if (set_en && (int'(set_vec[VEC_W-1:BIT_W]) == w))
                set_mask[set_vec[BIT_W-1:0]] = 1'b1;
            if (clr_en && (int'(clr_vec[VEC_W-1:BIT_W]) == w))
                clr_mask[clr_vec[BIT_W-1:0]] = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                words[w] <= '0;
            else
                words[w] <= (words[w] & ~clr_mask) | set_mask;
        end
    end
endmodule

// File: rtl/msb_finder.sv
module msb_finder #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int VEC_W = $clog2(WORDS * WORD_W),
    localparam int BIT_W = $clog2(WORD_W),
    localparam int WIDX_W = VEC_W - BIT_W
) (
    input  logic [WORDS-1:0][WORD_W-1:0] words,
    output logic [VEC_W-1:0]             top_vec,
    output logic                         any_set
);
    logic [WORDS-1:0]            word_nz;
    logic [WORDS-1:0][BIT_W-1:0] word_msb;

    for (genvar w = 0; w < WORDS; w++) begin : g_scan
        assign word_nz[w] = |words[w];
        always_comb begin
            word_msb[w] = '0;
            for (int b = 0; b < WORD_W; b++)
                if (words[w][b]) word_msb[w] = BIT_W'(b);
        end
    end

    always_comb begin
        logic [WIDX_W-1:0] sel_word;
        logic [BIT_W-1:0]  sel_bit;
        sel_word = '0;
        sel_bit  = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (word_nz[w]) begin
                sel_word = WIDX_W'(w);
                sel_bit  = word_msb[w];
            end
        end
        top_vec = {sel_word, sel_bit};
        any_set = |word_nz;
    end
endmodule

// File: rtl/spec_flags.sv
module spec_flags
    import irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  req_kind_e        req_kind,
    input  logic [VEC_W-1:0] req_vec,
    input  logic             take,
    output logic [VEC_W-1:0] spec_vec,
    output logic             spec_any,
    output logic             urgent
);
    logic [NUM_SPECIAL-1:0]            flag;
    logic [NUM_SPECIAL-1:0][VEC_W-1:0] stored;
    logic [NUM_SPECIAL-1:0]            higher;

    for (genvar k = 0; k < NUM_SPECIAL; k++) begin : g_slot
        logic hit;
        assign hit = req_valid && (int'(req_kind) == k + 1);
        if (k == 0) begin : g_first
            assign higher[k] = 1'b0;
        end else begin : g_rest
            assign higher[k] = higher[k-1] | flag[k-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag[k]   <= 1'b0;
                stored[k] <= '0;
            end else if (hit) begin
                flag[k]   <= 1'b1;
                stored[k] <= req_vec;
            end else if (take && flag[k] && !higher[k]) begin
                flag[k]   <= 1'b0;
            end
        end
    end

    always_comb begin
        spec_vec = '0;
        for (int k = NUM_SPECIAL - 1; k >= 0; k--)
            if (flag[k]) spec_vec = stored[k];
    end

    assign spec_any = |flag;
    assign urgent   = |flag[NUM_SPECIAL-2:0];

    // R8
    urgent_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(urgent) |-> $past(req_valid));
endmodule

// File: rtl/irq_vector_tracker.sv
module irq_vector_tracker
    import irq_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int VEC_W = $clog2(WORDS * WORD_W),
    localparam int CLS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [VEC_W-1:0] req_vec,
    input  logic             accept,
    input  logic             eoi,
    output logic [VEC_W-1:0] irr_top,
    output logic [VEC_W-1:0] isr_top,
    output logic [VEC_W-1:0] spec_vec,
    output logic             urgent_pending,
    output logic             int_pending
);
    req_kind_e kind;
    assign kind = req_kind_e'(req_kind);

    logic [WORDS-1:0][WORD_W-1:0] irr_words;
    logic [WORDS-1:0][WORD_W-1:0] isr_words;
    logic irr_any;
    logic isr_any;
    logic spec_any;
    logic take_array;
    logic fixed_req;

    assign fixed_req  = req_valid && (kind == KIND_FIXED);
    assign take_array = accept && !spec_any && irr_any;

    vec_bitmap #(.WORDS(WORDS), .WORD_W(WORD_W)) u_irr (
        .clk(clk), .rst_n(rst_n),
        .set_en(fixed_req), .set_vec(req_vec),
        .clr_en(take_array), .clr_vec(irr_top),
        .words(irr_words)
    );

    vec_bitmap #(.WORDS(WORDS), .WORD_W(WORD_W)) u_isr (
        .clk(clk), .rst_n(rst_n),
        .set_en(take_array), .set_vec(irr_top),
        .clr_en(eoi && isr_any), .clr_vec(isr_top),
        .words(isr_words)
    );

    msb_finder #(.WORDS(WORDS), .WORD_W(WORD_W)) u_irr_scan (
        .words(irr_words), .top_vec(irr_top), .any_set(irr_any)
    );

    msb_finder #(.WORDS(WORDS), .WORD_W(WORD_W)) u_isr_scan (
        .words(isr_words), .top_vec(isr_top), .any_set(isr_any)
    );

    spec_flags #(.VEC_W(VEC_W)) u_spec (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid && (kind != KIND_FIXED)),
        .req_kind(kind), .req_vec(req_vec),
        .take(accept),
        .spec_vec(spec_vec), .spec_any(spec_any), .urgent(urgent_pending)
    );

    logic cls_above;
    assign cls_above   = irr_any &&
        (irr_top[VEC_W-1 -: CLS_W] > isr_top[VEC_W-1 -: CLS_W]);
    assign int_pending = cls_above || spec_any;

    // R2
    req_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_req && !accept |=> irr_top >= $past(req_vec));

    // R4
    accept_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !spec_any && irr_any && !eoi |=> isr_top >= $past(irr_top));

    // R5
    eoi_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi && !accept |=> isr_top <= $past(isr_top));

    // R10
    spec_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && spec_any && !req_valid && !eoi |=>
        (irr_top == $past(irr_top)) && (isr_top == $past(isr_top)));

    // R9
    pending_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_pending && !spec_any |-> irr_any && (irr_top > isr_top));
endmodule

// File: tb/irq_vector_tracker_bench.sv
module irq_vector_tracker_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [7:0] req_vec = 8'd0;
    logic       accept = 1'b0;
    logic       eoi = 1'b0;
    logic [7:0] irr_top, isr_top, spec_vec;
    logic       urgent_pending, int_pending;

    int tests_run = 0;
    int tests_failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_tracker u_irq_vector_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_vec(req_vec),
        .accept(accept), .eoi(eoi),
        .irr_top(irr_top), .isr_top(isr_top), .spec_vec(spec_vec),
        .urgent_pending(urgent_pending), .int_pending(int_pending)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [2:0] k, input logic [7:0] v);
        req_valid = 1'b1; req_kind = k; req_vec = v;
        @(negedge clk);
        req_valid = 1'b0; req_kind = 3'd0; req_vec = 8'd0;
    endtask

    task automatic do_accept();
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 irr_top", irr_top, 0);
        chk("R1 isr_top", isr_top, 0);
        chk("R1 spec_vec", spec_vec, 0);
        chk("R1 urgent", urgent_pending, 0);
        chk("R1 pending", int_pending, 0);
        chk("R3 empty irr", irr_top, 0);
    endtask

    task automatic t_scan();
        do_req(3'd0, 8'd37);
        chk("R2 single", irr_top, 37);
        do_req(3'd0, 8'd200);
        chk("R2 higher word", irr_top, 200);
        do_req(3'd0, 8'd5);
        chk("R2 lower word", irr_top, 200);
    endtask

    task automatic t_accept_eoi();
        do_accept();
        chk("R4 isr gets 200", isr_top, 200);
        chk("R4 irr falls to 37", irr_top, 37);
        chk("R9 lower class", int_pending, 0);
        do_eoi();
        chk("R5 isr empty", isr_top, 0);
        chk("R3 isr zero", isr_top, 0);
        chk("R9 class above", int_pending, 1);
        do_accept();
        do_accept();
        chk("R4 isr keeps 37", isr_top, 37);
        chk("R3 irr empty", irr_top, 0);
        do_eoi();
        chk("R5 isr back to 5", isr_top, 5);
        do_eoi();
        chk("R5 isr empty again", isr_top, 0);
        do_eoi();
        chk("R5 eoi on empty", isr_top, 0);
    endtask

    task automatic t_dup();
        do_req(3'd0, 8'd50);
        do_req(3'd0, 8'd50);
        do_accept();
        chk("R6 irr after one accept", irr_top, 0);
        chk("R6 isr", isr_top, 50);
        do_eoi();
    endtask

    task automatic t_empty_accept();
        do_accept();
        chk("R11 isr untouched", isr_top, 0);
        do_req(3'd0, 8'd90);
        do_accept();
        do_accept();
        chk("R11 isr stays 90", isr_top, 90);
        chk("R11 irr stays 0", irr_top, 0);
        do_eoi();
    endtask

    task automatic t_class();
        do_req(3'd0, 8'd120);
        do_accept();
        do_req(3'd0, 8'd115);
        chk("R9 equal class", int_pending, 0);
        do_req(3'd0, 8'd130);
        chk("R9 higher class", int_pending, 1);
        do_reset();
        chk("R1 mid-run irr", irr_top, 0);
        chk("R1 mid-run isr", isr_top, 0);
    endtask

    task automatic t_special();
        do_req(3'd4, 8'h21);
        chk("R7 ext vec", spec_vec, 8'h21);
        chk("R8 ext not urgent", urgent_pending, 0);
        chk("R9 ext pends", int_pending, 1);
        chk("R7 array untouched", irr_top, 0);
        do_req(3'd3, 8'h40);
        chk("R7 init over ext", spec_vec, 8'h40);
        chk("R8 init urgent", urgent_pending, 1);
        do_req(3'd1, 8'h10);
        chk("R7 smi top", spec_vec, 8'h10);
        do_req(3'd2, 8'h02);
        chk("R7 nmi under smi", spec_vec, 8'h10);
        do_req(3'd0, 8'd120);
        do_accept();
        chk("R10 smi taken", spec_vec, 8'h02);
        chk("R10 irr kept", irr_top, 120);
        chk("R10 isr kept", isr_top, 0);
        do_accept();
        chk("R10 nmi taken", spec_vec, 8'h40);
        do_accept();
        chk("R10 init taken", spec_vec, 8'h21);
        chk("R8 only ext left", urgent_pending, 0);
        do_accept();
        chk("R7 none left", spec_vec, 0);
        chk("R9 array pends", int_pending, 1);
        do_accept();
        chk("R4 array taken", isr_top, 120);
        chk("R9 nothing pends", int_pending, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_scan();
        t_accept_eoi();
        t_dup();
        t_empty_accept();
        t_class();
        t_special();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule